// File: doc/BRIEF.md
# Host-Clocked Single-Wire-Data Serial Slave

This block is the slave end of a two-wire synchronous link. The host owns the clock line and paces every bit. One data line is shared by both directions. A local requester asks the block for one of three things: receive one byte from the host, send a byte to the host, or send one of two fixed reply codes (an acknowledge or a negative acknowledge). The block then follows the host's clock pulses until the frame is complete or has failed.

A frame takes eleven host clock pulses:

- a low start bit;
- eight data bits, least significant bit first;
- an even-parity bit;
- a high stop bit.

Both ends read the data line after the clock falls. When the slave sends, it changes the line only after the clock rises. A bad start bit, a bad stop bit or a parity mismatch ends the session at once. The block then stops following the clock and leaves the line released. If no clock edge arrives within a set number of system clocks, the transfer ends with a time-out.

The block runs on a fast system clock and passes both external lines through a synchroniser. A parameter inverts the polarity of both lines, for boards whose level shifters invert.

Top module: `tws_slave`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, `err_kind` is 0, and the data output is in its released state (logic high, which is a physical 1, or a physical 0 when inverted).
- R2: A receive request followed by a well-formed frame gives one `done` pulse with `err` low and `err_kind` 0. `rx_data` then holds the eight data bits, the first one sent being bit 0.
- R3: A start bit read high ends the receive after that first pulse with one `done` pulse, `err` high and `err_kind` 2 (framing).
- R4: A parity bit that is not the XOR of the eight data bits ends the receive at that bit with `err` high and `err_kind` 3 (parity).
- R5: A stop bit read low ends the receive with `err` high and `err_kind` 2.
- R6: A transmit request sends a frame, one bit per host pulse, in this order: 0, `tx_byte` bits 0 to 7, their even parity, then 1. The output changes only in response to a rising host clock edge.
- R7: An acknowledge request sends data byte ACK_CODE (default 0x06). A negative-acknowledge request sends NAK_CODE (default 0x15). Both use the R6 framing.
- R8: While busy, if TIMEOUT_CYC system clocks pass with no host clock edge, the transfer ends in both directions with one `done` pulse, `err` high and `err_kind` 1, and the line is released.
- R9: The data output stays released whenever the block is idle or receiving.
- R10: With INVERT set, both lines are inverted and the block behaves as in R2 to R7, seen through that inversion.
- R11: Requests that arrive while `busy` is high are ignored. A request accepted while idle clears `err` and `err_kind` in the same cycle that `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Host clock line (asynchronous) |
| sda_in | input | 1 | Data line as read back (asynchronous) |
| sda_out | output | 1 | Data line drive value; released level when not sending |
| rx_req | input | 1 | Start a receive (one-cycle pulse) |
| tx_req | input | 1 | Start sending `tx_byte` |
| ack_req | input | 1 | Start sending ACK_CODE |
| nak_req | input | 1 | Start sending NAK_CODE |
| tx_byte | input | 8 | Byte to send on `tx_req` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| err | output | 1 | Last transfer ended in error (held) |
| err_kind | output | 2 | 0 none, 1 time-out, 2 framing, 3 parity (held) |
| rx_data | output | 8 | Last byte received without error |

## Verification
The bench goes after each way a receive can fail:

- **Bad start bit.** The host stops after one pulse. A design that kept going would never finish and would leave `busy` high.
- **Flipped parity bit.** A design that computed odd parity, or skipped the check, would report success or the wrong error kind.
- **Low stop bit.** A design that skipped the check would report success.

Sent frames are rebuilt bit by bit from the line as the host samples it. A design that shifted the byte out most significant bit first, or changed the line on the falling edge, would give a wrong frame.

Time-outs are forced in both directions, including partway through a transmit. A request made in the middle of a receive must neither disturb the byte nor pull the line low.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int FRAME_LEN = 11;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int LAST_IDX  = FRAME_LEN - 1;
    localparam int PAR_IDX   = FRAME_LEN - 2;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RX   = 2'd1,
        M_TX   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        FAULT_NONE    = 2'd0,
        FAULT_TIMEOUT = 2'd1,
        FAULT_FRAMING = 2'd2,
        FAULT_PARITY  = 2'd3
    } fault_e;

    // Host clock events, already synchronised and in logical polarity.
    typedef struct packed {
        logic rise;
        logic fall;
    } clk_evt_t;

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    // Line value for frame position idx: start, data (LSB first), parity, stop.
    function automatic logic frame_bit(input logic [7:0] d, input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] k;
        k = idx - 1'b1;
        if (idx == '0)
            return 1'b0;
        else if (idx == IDX_W'(PAR_IDX))
            return even_par(d);
        else if (idx >= IDX_W'(LAST_IDX))
            return 1'b1;
        else
            return d[k[2:0]];
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter bit INVERT = 1'b0,
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_pin,
    input  logic     sda_pin,
    output clk_evt_t evt,
    output logic     sda_lvl
);

    logic              sck_l;
    logic              sda_l;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sda_q;
    logic              sck_prev;

    generate
        if (INVERT) begin : g_inv
            assign sck_l = ~sck_pin;
            assign sda_l = ~sda_pin;
        end else begin : g_pass
            assign sck_l = sck_pin;
            assign sda_l = sda_pin;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= '0;
            sda_q    <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck_l};
            sda_q    <= {sda_q[STAGES-2:0], sda_l};
            sck_prev <= sck_q[STAGES-1];
        end
    end

    assign evt.rise = sck_q[STAGES-1] & ~sck_prev;
    assign evt.fall = ~sck_q[STAGES-1] & sck_prev;
    assign sda_lvl  = sda_q[STAGES-1];

endmodule

// File: rtl/tws_watchdog.sv
module tws_watchdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic kick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = arm && !kick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !arm || kick)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tws_frame_engine.sv
module tws_frame_engine
    import tws_pkg::*;
#(
    parameter logic [7:0] ACK_CODE = 8'h06,
    parameter logic [7:0] NAK_CODE = 8'h15
) (
    input  logic       clk,
    input  logic       rst,
    input  clk_evt_t   evt,
    input  logic       sda_lvl,
    input  logic       timeout,
    input  logic       rx_req,
    input  logic       tx_req,
    input  logic       ack_req,
    input  logic       nak_req,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       tx_active,
    output logic       drive,
    output logic       done,
    output logic       err,
    output fault_e     err_kind,
    output logic [7:0] rx_data
);

    mode_e            mode;
    logic [IDX_W-1:0] idx;
    logic [7:0]       shreg;
    logic [7:0]       txd;
    logic             fin;
    fault_e           fin_kind;

    assign busy      = (mode != M_IDLE);
    assign tx_active = (mode == M_TX);

    // End-of-transfer decision for this cycle.
    always_comb begin
        fin      = 1'b0;
        fin_kind = FAULT_NONE;
        if (mode != M_IDLE && timeout) begin
            fin      = 1'b1;
            fin_kind = FAULT_TIMEOUT;
        end else if (mode == M_RX && evt.fall) begin
            if (idx == '0 && sda_lvl) begin
                fin      = 1'b1;
                fin_kind = FAULT_FRAMING;
            end else if (idx == IDX_W'(PAR_IDX) && (sda_lvl != even_par(shreg))) begin
                fin      = 1'b1;
                fin_kind = FAULT_PARITY;
            end else if (idx == IDX_W'(LAST_IDX)) begin
                fin      = 1'b1;
                fin_kind = sda_lvl ? FAULT_NONE : FAULT_FRAMING;
            end
        end else if (mode == M_TX && evt.fall && idx == IDX_W'(LAST_IDX)) begin
            fin = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_IDLE;
            idx      <= '0;
            shreg    <= '0;
            txd      <= '0;
            drive    <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            err_kind <= FAULT_NONE;
            rx_data  <= '0;
        end else begin
            done <= 1'b0;
            if (fin) begin
                mode     <= M_IDLE;
                done     <= 1'b1;
                err      <= (fin_kind != FAULT_NONE);
                err_kind <= fin_kind;
                drive    <= 1'b1;
                if (mode == M_RX && fin_kind == FAULT_NONE)
                    rx_data <= shreg;
            end else begin
                unique case (mode)
                    M_IDLE: begin
                        idx   <= '0;
                        drive <= 1'b1;
                        if (rx_req) begin
                            mode     <= M_RX;
                            err      <= 1'b0;
                            err_kind <= FAULT_NONE;
                        end else if (tx_req || ack_req || nak_req) begin
                            mode     <= M_TX;
                            err      <= 1'b0;
                            err_kind <= FAULT_NONE;
                            txd      <= tx_req ? tx_byte : (ack_req ? ACK_CODE : NAK_CODE);
                        end
                    end
                    M_RX: begin
                        if (evt.fall) begin
                            if (idx != '0 && idx < IDX_W'(PAR_IDX))
                                shreg <= {sda_lvl, shreg[7:1]};
                            idx <= idx + 1'b1;
                        end
                    end
                    M_TX: begin
                        if (evt.rise)
                            drive <= frame_bit(txd, idx);
                        if (evt.fall)
                            idx <= idx + 1'b1;
                    end
                    default: mode <= M_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter bit         INVERT      = 1'b0,
    parameter int         TIMEOUT_CYC = 256,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ACK_CODE    = 8'h06,
    parameter logic [7:0] NAK_CODE    = 8'h15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_pin,
    input  logic       sda_in,
    output logic       sda_out,
    input  logic       rx_req,
    input  logic       tx_req,
    input  logic       ack_req,
    input  logic       nak_req,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [1:0] err_kind,
    output logic [7:0] rx_data
);

    clk_evt_t evt;
    logic     sda_lvl;
    logic     timeout;
    logic     drive;
    logic     tx_active;
    logic     sck_rise;
    fault_e   kind;

    tws_line_sync #(
        .INVERT (INVERT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck_pin (sck_pin),
        .sda_pin (sda_in),
        .evt     (evt),
        .sda_lvl (sda_lvl)
    );

    tws_watchdog #(
        .LIMIT (TIMEOUT_CYC)
    ) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .arm     (busy),
        .kick    (evt.rise | evt.fall),
        .expired (timeout)
    );

    tws_frame_engine #(
        .ACK_CODE (ACK_CODE),
        .NAK_CODE (NAK_CODE)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sda_lvl   (sda_lvl),
        .timeout   (timeout),
        .rx_req    (rx_req),
        .tx_req    (tx_req),
        .ack_req   (ack_req),
        .nak_req   (nak_req),
        .tx_byte   (tx_byte),
        .busy      (busy),
        .tx_active (tx_active),
        .drive     (drive),
        .done      (done),
        .err       (err),
        .err_kind  (kind),
        .rx_data   (rx_data)
    );

    assign err_kind = kind;
    assign sck_rise = evt.rise;

    generate
        if (INVERT) begin : g_out_inv
            assign sda_out = ~drive;
        end else begin : g_out_pass
            assign sda_out = drive;
        end
    endgenerate

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk #(
    parameter bit INVERT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] err_kind,
    input logic       sda_out,
    input logic       tx_active,
    input logic       sck_rise
);

    localparam logic RELEASED = INVERT ? 1'b0 : 1'b1;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    released_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> (sda_out == RELEASED));

    // R6
    tx_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active) && (sda_out != $past(sda_out))) |-> $past(sck_rise));

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!err && err_kind == 2'd0));

endmodule

bind tws_slave tws_slave_chk #(.INVERT(INVERT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_kind  (err_kind),
    .sda_out   (sda_out),
    .tx_active (tx_active),
    .sck_rise  (sck_rise)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb;

    localparam int TO   = 256;
    localparam int HALF = 10;
    localparam int NVEC = 6;
    // {data[11:4], corruption[3:2], expected err_kind[1:0]}
    // corruption: 0 none, 1 start high, 2 parity flipped, 3 stop low
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h00, 2'd0, 2'd0},
        {8'hFF, 2'd0, 2'd0},
        {8'hA5, 2'd0, 2'd0},
        {8'h3C, 2'd1, 2'd2},
        {8'h81, 2'd2, 2'd3},
        {8'h5A, 2'd3, 2'd2}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       host_d = 1'b1;
    logic       rx_req = 1'b0, tx_req = 1'b0, ack_req = 1'b0, nak_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;

    logic       so0, so1, busy0, busy1, done0, done1, err0, err1;
    logic [1:0] kind0, kind1;
    logic [7:0] rxd0, rxd1;
    logic       line0, line1_phys, sck_n;

    assign line0      = host_d & so0;
    assign line1_phys = ~(host_d & ~so1);
    assign sck_n      = ~sck;

    tws_slave #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .sck_pin(sck), .sda_in(line0), .sda_out(so0),
        .rx_req(rx_req), .tx_req(tx_req), .ack_req(ack_req), .nak_req(nak_req),
        .tx_byte(tx_byte), .busy(busy0), .done(done0), .err(err0),
        .err_kind(kind0), .rx_data(rxd0)
    );

    tws_slave #(.INVERT(1'b1), .TIMEOUT_CYC(TO)) u_dut_inv (
        .clk(clk), .rst(rst), .sck_pin(sck_n), .sda_in(line1_phys), .sda_out(so1),
        .rx_req(rx_req), .tx_req(tx_req), .ack_req(ack_req), .nak_req(nak_req),
        .tx_byte(tx_byte), .busy(busy1), .done(done1), .err(err1),
        .err_kind(kind1), .rx_data(rxd1)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done0_cnt = 0;
    int done1_cnt = 0;
    int hi_viol = 0;
    logic rx_phase = 1'b0;

    always @(negedge clk) begin
        if (done0) done0_cnt++;
        if (done1) done1_cnt++;
        if (rx_phase && (so0 !== 1'b1 || so1 !== 1'b0)) hi_viol++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic pulse_req(input int which, input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        case (which)
            0: rx_req = 1'b1;
            1: tx_req = 1'b1;
            2: ack_req = 1'b1;
            default: nak_req = 1'b1;
        endcase
        @(negedge clk);
        rx_req = 1'b0; tx_req = 1'b0; ack_req = 1'b0; nak_req = 1'b0;
    endtask

    task automatic host_send(input logic [7:0] d, input int bad);
        logic [10:0] f;
        f = {1'b1, ^d, d, 1'b0};
        if (bad == 1) f[0] = 1'b1;
        if (bad == 2) f[9] = ~f[9];
        if (bad == 3) f[10] = 1'b0;
        for (int i = 0; i < 11; i++) begin
            host_d = f[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
            if ((bad == 1 && i == 0) || (bad == 2 && i == 9)) break;
        end
        host_d = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_recv(input int npulses, output logic [10:0] f0, output logic [10:0] f1);
        f0 = '0;
        f1 = '0;
        host_d = 1'b1;
        for (int i = 0; i < npulses; i++) begin
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            f0[i] = line0;
            f1[i] = ~line1_phys;
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic tx_case(input int which, input logic [7:0] b, input logic [7:0] exp_byte,
                           input string tag);
        logic [10:0] f0, f1, ef;
        int d0, d1;
        d0 = done0_cnt;
        d1 = done1_cnt;
        ef = {1'b1, ^exp_byte, exp_byte, 1'b0};
        pulse_req(which, b);
        host_recv(11, f0, f1);
        check({tag, " frame"}, int'(f0), int'(ef));
        check("R10 inverted frame", int'(f1), int'(ef));
        check({tag, " done"}, done0_cnt - d0, 1);
        check("R10 done", done1_cnt - d1, 1);
        check({tag, " err"}, int'(err0), 0);
        check({tag, " busy"}, int'(busy0), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [10:0] g0, g1;
        int d0, d1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 busy", int'(busy0), 0);
        check("R1 done", int'(done0), 0);
        check("R1 err", int'(err0), 0);
        check("R1 err_kind", int'(kind0), 0);
        check("R1 line", int'(so0), 1);
        check("R1 inverted line", int'(so1), 0);
        check("R1 inverted busy", int'(busy1), 0);

        // Receive vectors: R2, R3, R4, R5, with R10 on the inverted copy
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            int bad, ek;
            string tag;
            d   = VEC[v][11:4];
            bad = int'(VEC[v][3:2]);
            ek  = int'(VEC[v][1:0]);
            case (bad)
                0: tag = "R2";
                1: tag = "R3";
                2: tag = "R4";
                default: tag = "R5";
            endcase
            d0 = done0_cnt;
            d1 = done1_cnt;
            pulse_req(0, 8'h00);
            rx_phase = 1'b1;
            host_send(d, bad);
            rx_phase = 1'b0;
            check({tag, " done"}, done0_cnt - d0, 1);
            check({tag, " err_kind"}, int'(kind0), ek);
            check({tag, " err"}, int'(err0), int'(ek != 0));
            check({tag, " busy"}, int'(busy0), 0);
            check("R10 done", done1_cnt - d1, 1);
            check("R10 err_kind", int'(kind1), ek);
            if (ek == 0) begin
                check({tag, " rx_data"}, int'(rxd0), int'(d));
                check("R10 rx_data", int'(rxd1), int'(d));
            end
        end
        check("R9 line held high while receiving", hi_viol, 0);

        // R6 transmit
        tx_case(1, 8'h96, 8'h96, "R6");
        tx_case(1, 8'h01, 8'h01, "R6");
        // R7 acknowledge / negative acknowledge
        tx_case(2, 8'hEE, 8'h06, "R7 ack");
        tx_case(3, 8'hEE, 8'h15, "R7 nak");

        // R8 time-out during receive with no clock
        d0 = done0_cnt;
        pulse_req(0, 8'h00);
        repeat (TO + 20) @(negedge clk);
        check("R8 rx timeout done", done0_cnt - d0, 1);
        check("R8 rx timeout kind", int'(kind0), 1);
        check("R8 rx timeout err", int'(err0), 1);
        check("R8 rx timeout busy", int'(busy0), 0);
        check("R8 inverted timeout kind", int'(kind1), 1);

        // R8 time-out partway through a transmit
        d0 = done0_cnt;
        pulse_req(1, 8'h55);
        host_recv(3, g0, g1);
        repeat (TO + 20) @(negedge clk);
        check("R8 tx timeout done", done0_cnt - d0, 1);
        check("R8 tx timeout kind", int'(kind0), 1);
        check("R8 tx timeout busy", int'(busy0), 0);
        check("R8 tx timeout line released", int'(so0), 1);

        // R11 request clears error; request while busy is ignored
        d0 = done0_cnt;
        hi_viol = 0;
        pulse_req(0, 8'h00);
        check("R11 err cleared on start", int'(err0), 0);
        check("R11 err_kind cleared on start", int'(kind0), 0);
        rx_phase = 1'b1;
        pulse_req(1, 8'h00);
        pulse_req(2, 8'h00);
        host_send(8'hC3, 0);
        rx_phase = 1'b0;
        check("R11 rx_data after ignored request", int'(rxd0), 8'hC3);
        check("R11 single done", done0_cnt - d0, 1);
        check("R11 err", int'(err0), 0);
        check("R11 no transmit started", hi_viol, 0);
        repeat (TO + 20) @(negedge clk);
        check("R11 stays idle", int'(busy0), 0);
        check("R11 no extra done", done0_cnt - d0, 1);

        summary();
        $finish;
    end

endmodule